// File: doc/BRIEF.md
# Block Storage DMA Control Registers

This block is the register-side target of a DMA block-storage controller. Software programs a memory buffer address, a block count and a first block index, then writes an operation code to launch a transfer. The block hands a one-cycle start pulse and the programmed parameters to a separate DMA engine. The engine reports its state back, and that state is what software reads as the status value.

When the engine reports one of the four completion states, the block raises an interrupt if interrupts are enabled. A status read taken in a completion state acknowledges it. The interrupt drops at once and a one-cycle clear pulse tells the engine to return to idle. While the engine is not idle, or a start is still in flight, writes to the transfer parameters and to the operation register are dropped. This stops a running transfer from being reprogrammed.

The bus side is a single-word request/response target. A request is accepted on `req_valid && req_ready`. Its write data and requester identifiers are captured at that edge, so the requester may change them afterwards. The response slot holds one entry. It is presented on `rsp_valid` and leaves on `rsp_valid && rsp_ready`. Back-pressure on the response channel stalls further requests through `req_ready`.

Top module: `blkdev_regs`

## Requirements
- R1: After reset, the address, count, index and high-address registers read 0. Interrupt enable reads 1. `irq`, `rsp_valid`, `eng_start` and `eng_clear` are 0 and `req_ready` is 1.
- R2: While the engine state is 0 (idle) and no start is in flight, a write stores data into the register at that offset, and a read returns it. The offsets are 0x00 (buffer address low), 0x04 (block count), 0x08 (first block index) and 0x20 (buffer address high). The high register keeps only its low `BUF_ADDR_W-32` bits. Offset 0x14 (interrupt enable) is writable in any state; it stores 1 for any non-zero data and reads back as 0 or 1.
- R3: A read of 0x10 returns `eng_state` zero-extended. A read of 0x18 returns `DEV_BLOCKS`. A read of 0x1C returns `BLOCK_BYTES`.
- R4: The block answers with `rsp_err`=1 and `rsp_rdata`=0, and changes no state, for any of these accesses: an offset with non-zero low two bits; an offset above 0x20; a write to 0x10, 0x18 or 0x1C; a read of 0x0C.
- R5: While `eng_state` is non-zero or `eng_start` is high, writes to 0x00, 0x04, 0x08, 0x0C and 0x20 complete with `rsp_err`=0 and have no effect.
- R6: A write to 0x0C accepted under the R2 conditions produces `eng_start` high for exactly the next cycle, but only when the data is 1 or 2. `eng_dir` is 0 for code 1 (device to memory) and 1 for code 2 (memory to device). Code 0 and all other codes start nothing. `eng_buf_addr`, `eng_count` and `eng_lba` always show the stored registers, with the high register above the low one.
- R7: `irq` is 1 exactly when `eng_state` is 2, 3, 4 or 5, interrupt enable is 1, and the completion has not been acknowledged.
- R8: A read of 0x10 accepted while `eng_state` is in 2..5 acknowledges the completion. `irq` is 0 from the cycle after acceptance, and `eng_clear` is high for that one cycle. The acknowledgement lasts until `eng_state` leaves 2..5.
- R9: A response carries the source, transaction and packet identifiers present at acceptance. Write data takes effect as it was at acceptance, and later changes to the request pins have no effect.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. Each accepted request yields exactly one response, in order, on the cycle after acceptance. A response held by `!rsp_ready` keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| req_srcid | input | SRC_W | Requester source identifier |
| req_trdid | input | TRD_W | Transaction identifier |
| req_pktid | input | PKT_W | Packet identifier |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high |
| rsp_rdata | output | 32 | Read data, 0 on writes and errors |
| rsp_err | output | 1 | Access refused |
| rsp_srcid | output | SRC_W | Echoed source identifier |
| rsp_trdid | output | TRD_W | Echoed transaction identifier |
| rsp_pktid | output | PKT_W | Echoed packet identifier |
| eng_start | output | 1 | One-cycle launch pulse to the DMA engine |
| eng_dir | output | 1 | 0 device to memory, 1 memory to device |
| eng_buf_addr | output | BUF_ADDR_W | Memory buffer address |
| eng_count | output | 32 | Blocks to transfer |
| eng_lba | output | 32 | First block index |
| eng_state | input | 3 | Engine state: 0 idle, 1 busy, 2 read ok, 3 write ok, 4 read error, 5 write error |
| eng_clear | output | 1 | One-cycle pulse returning the engine to idle |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that `eng_state` never takes the values 6 or 7. They also assume that the engine follows a start pulse by leaving idle, and never becomes busy unprompted. The stimulus moves `eng_state` only between the six defined codes, and only on the falling clock edge. It leaves the state idle across the random phase so that start pulses may repeat. The response-stability property relies on the requester not dropping `rsp_ready` mid-handshake in any unusual way. The bench toggles `rsp_ready` at random, but only on falling edges.

// File: rtl/blkdev_pkg.sv
package blkdev_pkg;
  localparam int REG_W = 32;

  typedef enum logic [3:0] {
    SEL_BUF_LO = 4'd0,
    SEL_COUNT  = 4'd1,
    SEL_LBA    = 4'd2,
    SEL_OP     = 4'd3,
    SEL_STATUS = 4'd4,
    SEL_IRQEN  = 4'd5,
    SEL_DEVSZ  = 4'd6,
    SEL_BLKSZ  = 4'd7,
    SEL_BUF_HI = 4'd8,
    SEL_NONE   = 4'd15
  } reg_sel_e;

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_BUSY = 3'd1;

  localparam logic [REG_W-1:0] OPC_TO_MEM   = 32'd1;
  localparam logic [REG_W-1:0] OPC_FROM_MEM = 32'd2;

  function automatic logic is_done(input logic [2:0] st);
    return (st >= 3'd2) && (st <= 3'd5);
  endfunction

  // registers frozen while a transfer is pending or running
  function automatic logic is_locked(input reg_sel_e s);
    return (s == SEL_BUF_LO) || (s == SEL_COUNT) || (s == SEL_LBA) ||
           (s == SEL_OP) || (s == SEL_BUF_HI);
  endfunction
endpackage

// File: rtl/blkdev_decode.sv
module blkdev_decode
  import blkdev_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  output reg_sel_e          sel,
  output logic              err
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int LAST_IDX = 8;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00 && int'(idx) <= LAST_IDX)
      sel = reg_sel_e'(4'(idx));
  end

  always_comb begin
    err = 1'b0;
    if (sel == SEL_NONE) err = 1'b1;
    else if (write && (sel == SEL_STATUS || sel == SEL_DEVSZ || sel == SEL_BLKSZ))
      err = 1'b1;
    else if (!write && sel == SEL_OP) err = 1'b1;
  end
endmodule

// File: rtl/blkdev_cfg.sv
module blkdev_cfg
  import blkdev_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             busy,
  output logic [REG_W-1:0] buf_lo,
  output logic [HI_W-1:0]  buf_hi,
  output logic [REG_W-1:0] count,
  output logic [REG_W-1:0] lba,
  output logic             irq_en,
  output logic             start,
  output logic             dir
);
  logic allow;
  assign allow = wr_en && !(busy && is_locked(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_lo <= '0;
      buf_hi <= '0;
      count  <= '0;
      lba    <= '0;
      irq_en <= 1'b1;
      start  <= 1'b0;
      dir    <= 1'b0;
    end else begin
      start <= 1'b0;
      if (allow) begin
        unique case (sel)
          SEL_BUF_LO: buf_lo <= wdata;
          SEL_BUF_HI: buf_hi <= wdata[HI_W-1:0];
          SEL_COUNT:  count  <= wdata;
          SEL_LBA:    lba    <= wdata;
          SEL_IRQEN:  irq_en <= |wdata;
          SEL_OP: begin
            if (wdata == OPC_TO_MEM || wdata == OPC_FROM_MEM) begin
              start <= 1'b1;
              dir   <= (wdata == OPC_FROM_MEM);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/blkdev_rsp_slot.sv
module blkdev_rsp_slot
  import blkdev_pkg::*;
#(
  parameter int SRC_W = 8,
  parameter int TRD_W = 4,
  parameter int PKT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] in_rdata,
  input  logic             in_err,
  input  logic [SRC_W-1:0] in_src,
  input  logic [TRD_W-1:0] in_trd,
  input  logic [PKT_W-1:0] in_pkt,
  input  logic             take,
  output logic             valid,
  output logic [REG_W-1:0] rdata,
  output logic             err,
  output logic [SRC_W-1:0] src,
  output logic [TRD_W-1:0] trd,
  output logic [PKT_W-1:0] pkt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      rdata <= '0;
      err   <= 1'b0;
      src   <= '0;
      trd   <= '0;
      pkt   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      rdata <= in_err ? '0 : in_rdata;
      err   <= in_err;
      src   <= in_src;
      trd   <= in_trd;
      pkt   <= in_pkt;
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/blkdev_regs.sv
module blkdev_regs
  import blkdev_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter int          BUF_ADDR_W  = 40,
  parameter int          SRC_W       = 8,
  parameter int          TRD_W       = 4,
  parameter int          PKT_W       = 4,
  parameter int unsigned DEV_BLOCKS  = 65536,
  parameter int unsigned BLOCK_BYTES = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [31:0]           req_wdata,
  input  logic [SRC_W-1:0]      req_srcid,
  input  logic [TRD_W-1:0]      req_trdid,
  input  logic [PKT_W-1:0]      req_pktid,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_rdata,
  output logic                  rsp_err,
  output logic [SRC_W-1:0]      rsp_srcid,
  output logic [TRD_W-1:0]      rsp_trdid,
  output logic [PKT_W-1:0]      rsp_pktid,
  output logic                  eng_start,
  output logic                  eng_dir,
  output logic [BUF_ADDR_W-1:0] eng_buf_addr,
  output logic [31:0]           eng_count,
  output logic [31:0]           eng_lba,
  input  logic [2:0]            eng_state,
  output logic                  eng_clear,
  output logic                  irq
);
  localparam int HI_W = BUF_ADDR_W - REG_W;

  reg_sel_e         sel;
  logic             dec_err;
  logic             accept;
  logic             done;
  logic             busy;
  logic             ack_hit;
  logic             ack_held;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] buf_lo;
  logic [HI_W-1:0]  buf_hi;
  logic             irq_en;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign done      = is_done(eng_state);
  assign busy      = (eng_state != ST_IDLE) || eng_start;
  assign ack_hit   = accept && !req_write && (sel == SEL_STATUS) && done;

  blkdev_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (req_addr),
    .write (req_write),
    .sel   (sel),
    .err   (dec_err)
  );

  blkdev_cfg #(.HI_W(HI_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (accept && req_write && !dec_err),
    .sel    (sel),
    .wdata  (req_wdata),
    .busy   (busy),
    .buf_lo (buf_lo),
    .buf_hi (buf_hi),
    .count  (eng_count),
    .lba    (eng_lba),
    .irq_en (irq_en),
    .start  (eng_start),
    .dir    (eng_dir)
  );

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      unique case (sel)
        SEL_BUF_LO: rd_mux = buf_lo;
        SEL_BUF_HI: rd_mux = REG_W'(buf_hi);
        SEL_COUNT:  rd_mux = eng_count;
        SEL_LBA:    rd_mux = eng_lba;
        SEL_STATUS: rd_mux = REG_W'(eng_state);
        SEL_IRQEN:  rd_mux = REG_W'(irq_en);
        SEL_DEVSZ:  rd_mux = REG_W'(DEV_BLOCKS);
        SEL_BLKSZ:  rd_mux = REG_W'(BLOCK_BYTES);
        default:    rd_mux = '0;
      endcase
    end
  end

  blkdev_rsp_slot #(.SRC_W(SRC_W), .TRD_W(TRD_W), .PKT_W(PKT_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .in_rdata (rd_mux),
    .in_err   (dec_err),
    .in_src   (req_srcid),
    .in_trd   (req_trdid),
    .in_pkt   (req_pktid),
    .take     (rsp_ready),
    .valid    (rsp_valid),
    .rdata    (rsp_rdata),
    .err      (rsp_err),
    .src      (rsp_srcid),
    .trd      (rsp_trdid),
    .pkt      (rsp_pktid)
  );

  // completion acknowledgement: held until the engine leaves the done states
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_held  <= 1'b0;
      eng_clear <= 1'b0;
    end else begin
      eng_clear <= ack_hit;
      if (ack_hit) ack_held <= 1'b1;
      else if (!done) ack_held <= 1'b0;
    end
  end

  assign eng_buf_addr = {buf_hi, buf_lo};
  assign irq          = irq_en && done && !ack_held;
endmodule

// File: rtl/blkdev_regs_chk.sv
module blkdev_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic       rsp_err,
  input logic       eng_start,
  input logic [2:0] eng_state,
  input logic       eng_clear,
  input logic       irq
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R6

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_start) |-> $past(eng_state) == 3'd0); // R5

  AST_IRQ_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (eng_state >= 3'd2 && eng_state <= 3'd5)); // R7

  AST_CLEAR_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    eng_clear |-> !irq); // R8

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R10

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R10
endmodule

bind blkdev_regs blkdev_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .eng_start (eng_start),
  .eng_state (eng_state),
  .eng_clear (eng_clear),
  .irq       (irq)
);

// File: tb/blkdev_regs_tb.sv
`timescale 1ns/1ps
module blkdev_regs_tb;
  localparam int HI_W = 8;
  localparam int unsigned DEVB = 65536;
  localparam int unsigned BLKB = 512;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [5:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [7:0] req_srcid = 0;
  logic [3:0] req_trdid = 0, req_pktid = 0;
  logic req_ready, rsp_valid, rsp_err, eng_start, eng_dir, eng_clear, irq;
  logic rsp_ready = 1;
  logic [31:0] rsp_rdata, eng_count, eng_lba;
  logic [7:0] rsp_srcid;
  logic [3:0] rsp_trdid, rsp_pktid;
  logic [39:0] eng_buf_addr;
  logic [2:0] eng_state = 0;

  int checks = 0, errors = 0;
  bit bp_mode = 0;
  string rd_tag = "R1";

  always #2.5 clk = ~clk;

  blkdev_regs u_dut (.*);

  typedef struct {
    logic [31:0] rdata; bit err;
    logic [7:0] src; logic [3:0] trd; logic [3:0] pkt;
    string tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] m_lo, m_cnt, m_lba, m_hi;
  bit m_ien, m_clr, m_start, m_dir, m_clrp, m_rv;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_cnt = 0; m_lba = 0; m_hi = 0; m_ien = 1; m_clr = 0;
      m_start = 0; m_dir = 0; m_clrp = 0; m_rv = 0; q.delete();
    end else begin
      bit rdy, busy, done, acc, n_start, n_clrp;
      exp_t e;
      rdy = !m_rv || rsp_ready;
      busy = (eng_state != 0) || m_start;
      done = eng_state >= 2 && eng_state <= 5;
      acc = req_valid && rdy;
      n_start = 0; n_clrp = 0;
      if (m_rv && rsp_ready && q.size() > 0) void'(q.pop_front());
      if (acc) begin
        e.rdata = 0; e.err = 0; e.src = req_srcid; e.trd = req_trdid; e.pkt = req_pktid;
        e.tag = busy ? "R5" : rd_tag;
        if (req_addr[1:0] != 0 || req_addr > 6'h20) begin e.err = 1; e.tag = "R4"; end
        else case (req_addr >> 2)
          0: if (req_write) begin if (!busy) m_lo = req_wdata; end else e.rdata = m_lo;
          1: if (req_write) begin if (!busy) m_cnt = req_wdata; end else e.rdata = m_cnt;
          2: if (req_write) begin if (!busy) m_lba = req_wdata; end else e.rdata = m_lba;
          3: if (req_write) begin
               if (!busy && (req_wdata == 1 || req_wdata == 2)) begin n_start = 1; m_dir = (req_wdata == 2); end
             end else begin e.err = 1; e.tag = "R4"; end
          4: if (req_write) begin e.err = 1; e.tag = "R4"; end
             else begin
               e.rdata = 32'(eng_state); e.tag = "R3";
               if (done) begin n_clrp = 1; m_clr = 1; e.tag = "R8"; end
             end
          5: if (req_write) m_ien = (req_wdata != 0); else e.rdata = 32'(m_ien);
          6: if (req_write) begin e.err = 1; e.tag = "R4"; end else begin e.rdata = DEVB; e.tag = "R3"; end
          7: if (req_write) begin e.err = 1; e.tag = "R4"; end else begin e.rdata = BLKB; e.tag = "R3"; end
          default: if (req_write) begin if (!busy) m_hi = req_wdata & 32'hFF; end else e.rdata = m_hi;
        endcase
        q.push_back(e);
      end
      if (!done) m_clr = 0;
      m_start = n_start; m_clrp = n_clrp;
      m_rv = acc ? 1'b1 : (rsp_ready ? 1'b0 : m_rv);
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit done;
      done = eng_state >= 2 && eng_state <= 5;
      chk("R10", "req_ready", req_ready, !m_rv || rsp_ready);
      chk("R10", "rsp_valid", rsp_valid, m_rv);
      if (m_rv && q.size() > 0) begin
        chk(q[0].tag, "rsp_rdata", rsp_rdata, q[0].rdata);
        chk(q[0].tag, "rsp_err", rsp_err, q[0].err);
        chk("R9", "rsp_ids", {rsp_srcid, rsp_trdid, rsp_pktid}, {q[0].src, q[0].trd, q[0].pkt});
      end
      chk(m_clr ? "R8" : "R7", "irq", irq, m_ien && done && !m_clr);
      chk("R6", "eng_start", eng_start, m_start);
      if (m_start) chk("R6", "eng_dir", eng_dir, m_dir);
      chk("R6", "eng_buf_addr", eng_buf_addr, {m_hi[HI_W-1:0], m_lo});
      chk("R6", "eng_count", eng_count, m_cnt);
      chk("R6", "eng_lba", eng_lba, m_lba);
      chk("R8", "eng_clear", eng_clear, m_clrp);
    end
  end

  always @(negedge clk) rsp_ready <= bp_mode ? 1'($urandom % 2) : 1'b1;

  task automatic access(input bit w, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    req_srcid = 8'($urandom); req_trdid = 4'($urandom); req_pktid = 4'($urandom);
    while (1) begin
      #1;
      if (req_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    req_valid = 0; req_wdata = ~d;
    req_srcid = 8'($urandom); req_trdid = 4'($urandom); req_pktid = 4'($urandom);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1;
    #3;
    chk("R1", "req_ready", req_ready, 1); chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "irq", irq, 0); chk("R1", "eng_start", eng_start, 0); chk("R1", "eng_clear", eng_clear, 0);
    // R1 readback of reset values
    access(0, 6'h00, 0); access(0, 6'h04, 0); access(0, 6'h08, 0);
    access(0, 6'h20, 0); access(0, 6'h14, 0);
    settle(2);
    rd_tag = "R2";
    access(1, 6'h00, 32'hDEAD_BEE0); access(1, 6'h04, 32'd7); access(1, 6'h08, 32'h0012_3456);
    access(1, 6'h20, 32'hFFFF_FFFF); access(1, 6'h14, 32'h0000_0100);
    access(0, 6'h00, 0); access(0, 6'h04, 0); access(0, 6'h08, 0); access(0, 6'h20, 0); access(0, 6'h14, 0);
    // R3 read-only values
    access(0, 6'h10, 0); access(0, 6'h18, 0); access(0, 6'h1C, 0);
    // R4 refused accesses, then state unchanged
    access(0, 6'h24, 0); access(1, 6'h3C, 1); access(0, 6'h02, 0); access(1, 6'h01, 5);
    access(1, 6'h10, 9); access(1, 6'h18, 9); access(1, 6'h1C, 9); access(0, 6'h0C, 0);
    access(0, 6'h00, 0); access(0, 6'h18, 0);
    // R6 no-op and unknown codes start nothing
    access(1, 6'h0C, 0); access(1, 6'h0C, 3); settle(2);
    // R6 read launch
    access(1, 6'h0C, 1);
    eng_state = 1;
    // R5 locked writes while busy
    access(1, 6'h04, 32'd99); access(1, 6'h00, 32'h1); access(1, 6'h08, 32'h2);
    access(1, 6'h20, 32'h3); access(1, 6'h0C, 2);
    access(0, 6'h04, 0); access(0, 6'h10, 0);
    // R7 completion raises irq; enable gates it
    eng_state = 2; settle(3);
    access(1, 6'h14, 0); settle(2);
    access(1, 6'h14, 1); settle(2);
    // R8 acknowledge by status read
    access(0, 6'h10, 0); settle(4);
    eng_state = 0; settle(2);
    rd_tag = "R2";
    access(1, 6'h04, 32'd3);
    access(1, 6'h0C, 2);
    eng_state = 1; settle(3);
    eng_state = 5; settle(2);
    eng_state = 3; settle(2);
    eng_state = 4; settle(2);
    access(0, 6'h10, 0); settle(2);
    eng_state = 5; settle(2);
    eng_state = 0; settle(2);
    eng_state = 3; settle(2);
    access(0, 6'h10, 0); settle(2);
    eng_state = 0; settle(2);
    // R9 R10 random traffic under back-pressure
    bp_mode = 1;
    for (int i = 0; i < 400; i++) begin
      logic [5:0] a;
      a = {4'($urandom % 10), (($urandom % 6) == 0) ? 2'($urandom) : 2'b00};
      if (a[5:2] == 4'd3 && ($urandom % 2) == 0) access(1, a, $urandom % 4);
      else access(1'($urandom), a, $urandom);
    end
    bp_mode = 0;
    settle(6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule